// File: doc/BRIEF.md
# Six-Stage Pipeline Branch Flush Controller

This block follows the instructions that occupy a six-stage in-order pipeline: fetch (FI), decode (DI), operand-address calculation (CO), operand fetch (FO), execute (EI) and write output (WO). It stores one valid bit, one program counter, one branch class and one branch target for each stage. Every cycle, each entry moves one stage further, and a new instruction can enter FI. The fetch program counter is kept inside the block. Fetch is sequential and follows a predict-not-taken policy, so instructions after a branch keep arriving until that branch resolves.

The two branch classes resolve in different stages. An unconditional branch redirects fetch once it leaves CO, and the two younger instructions behind it are discarded. A conditional branch whose outcome is taken redirects fetch once it leaves EI, and the four younger instructions are discarded. A redirect from EI wins over a redirect from CO raised in the same cycle. Every valid instruction that a flush throws away counts as one penalty bubble, and a counter adds these bubbles up. Operand hazards, memory conflicts and the datapath itself are outside this block.

Top module: `pipe_flush_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all stage valid bits, the penalty count and the redirect output are cleared, and the fetch counter returns to `RESET_PC` (default 0).
- R2: If no redirect is raised, every stage takes the valid bit and PC of the stage before it at each edge. When `fetch_en` is high, FI takes the fetch counter and the counter then advances by 1. Packing: stage k is bit k of `stg_valid` and `stg_pc[k*PC_W +: PC_W]`, with FI=0, DI=1, CO=2, FO=3, EI=4, WO=5.
- R3: A valid instruction of class 2'b01 (unconditional) in CO raises `redirect_valid` in the same cycle, with `redirect_pc` equal to its target. At the next edge, DI and CO become invalid, FI takes the target (if `fetch_en`) and fetch continues from target+1.
- R4: A valid instruction of class 2'b10 (conditional) in EI with `ex_taken` high raises a redirect to its target. At the next edge, DI, CO, FO and EI become invalid and FI takes the target.
- R5: A conditional branch with `ex_taken` low in EI, or a conditional branch in CO, causes no redirect, no flush and no penalty.
- R6: If EI and CO raise a redirect in the same cycle, the EI target is used and the four-stage flush takes place.
- R7: `penalty_cnt` increases by the number of valid instructions that a redirect discards and does not change in any other cycle.
- R8: A discarded instruction never reaches WO. WO shows only surviving instructions, in program order.
- R9: Classes 2'b00 and 2'b11 are plain instructions. `ex_taken` has no effect unless EI holds a valid conditional branch.
- R10: With `fetch_en` low, FI becomes invalid and the fetch counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_en | input | 1 | An instruction enters FI this cycle |
| fetch_kind | input | 2 | Branch class of the fetched instruction |
| fetch_target | input | PC_W | Branch target of the fetched instruction |
| ex_taken | input | 1 | Outcome of the conditional branch in EI |
| stg_valid | output | 6 | Valid bit per stage, FI in bit 0 |
| stg_pc | output | 6*PC_W | PC per stage, FI in the low slice |
| redirect_valid | output | 1 | A branch redirects fetch at the coming edge |
| redirect_pc | output | PC_W | Target of the redirect |
| penalty_cnt | output | PEN_W | Total bubbles inserted by flushes |

## Verification
If the kill mask is wrong, the error appears one edge after the redirect. The stage valid pattern then shows too few or too many holes, and a squashed PC can reach WO four cycles later. A wrong fetch counter or a wrong choice of target appears at the FI PC in the first cycle after a redirect. An incorrect bubble count shows up in `penalty_cnt` at that same edge. The stimulus table puts both branch classes, an ignored class, an ignored outcome and a simultaneous CO/EI redirect on known PCs, so each of these faults is caught at the first edge where it has any effect.

// File: rtl/pfc_pkg.sv
// Package: shared stage indices and the branch class encoding for the
// flush controller. Assumes a fixed six-stage in-order pipeline.
package pfc_pkg;

    localparam int unsigned NUM_STG = 6;
    localparam int unsigned S_FI = 0;
    localparam int unsigned S_DI = 1;
    localparam int unsigned S_CO = 2;
    localparam int unsigned S_FO = 3;
    localparam int unsigned S_EI = 4;
    localparam int unsigned S_WO = 5;

    typedef enum logic [1:0] {
        BR_NONE   = 2'b00,
        BR_UNCOND = 2'b01,
        BR_COND   = 2'b10,
        BR_RSVD   = 2'b11
    } br_kind_e;

endpackage

// File: rtl/pfc_slot.sv
// Module: one pipeline stage slot. It captures the entry handed over by
// the previous stage and clears the valid bit when kill is high.
// Assumes: kill applies to the incoming entry, not the one held.
module pfc_slot
    import pfc_pkg::*;
#(
    parameter int unsigned PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [PC_W-1:0] in_pc,
    input  br_kind_e        in_kind,
    input  logic [PC_W-1:0] in_tgt,
    input  logic            kill,
    output logic            q_vld,
    output logic [PC_W-1:0] q_pc,
    output br_kind_e        q_kind,
    output logic [PC_W-1:0] q_tgt
);

    // Purpose: advance one entry per cycle and drop it when squashed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld  <= 1'b0;
            q_pc   <= '0;
            q_kind <= BR_NONE;
            q_tgt  <= '0;
        end else begin
            q_vld  <= in_vld & ~kill;
            q_pc   <= in_pc;
            q_kind <= in_kind;
            q_tgt  <= in_tgt;
        end
    end

endmodule

// File: rtl/pfc_resolve.sv
// Module: branch resolution. Finds an unconditional branch leaving CO and
// a taken conditional branch leaving EI, picks the older one (EI) when
// both are present, and builds the per-slot kill mask.
// Assumes: stage contents are registered, so this logic is purely
// combinational on those registers and ex_taken.
module pfc_resolve
    import pfc_pkg::*;
#(
    parameter int unsigned PC_W = 16
) (
    input  logic               co_vld,
    input  br_kind_e           co_kind,
    input  logic [PC_W-1:0]    co_tgt,
    input  logic               ei_vld,
    input  br_kind_e           ei_kind,
    input  logic [PC_W-1:0]    ei_tgt,
    input  logic               ex_taken,
    output logic               co_hit,
    output logic               ei_hit,
    output logic               redir_vld,
    output logic [PC_W-1:0]    redir_pc,
    output logic [NUM_STG-1:0] kill
);

    int unsigned last_killed;

    // Purpose: detect the early and late redirect conditions.
    always_comb begin
        co_hit = co_vld && (co_kind == BR_UNCOND);
        ei_hit = ei_vld && (ei_kind == BR_COND) && ex_taken;
    end

    // Purpose: choose the target and the deepest stage to squash.
    always_comb begin
        redir_vld   = co_hit || ei_hit;
        redir_pc    = ei_hit ? ei_tgt : co_tgt;
        last_killed = ei_hit ? S_EI : S_CO;
    end

    // Purpose: squash the incoming entries of stages DI up to the limit.
    for (genvar g = 0; g < NUM_STG; g++) begin : g_kill
        if (g == S_FI) begin : g_fi
            assign kill[g] = 1'b0;
        end else begin : g_rest
            assign kill[g] = redir_vld && (g <= last_killed);
        end
    end

endmodule

// File: rtl/pfc_fetch.sv
// Module: fetch counter. Supplies the PC of the instruction entering FI
// and follows redirects. Assumes sequential fetch (predict not taken).
module pfc_fetch #(
    parameter int unsigned          PC_W     = 16,
    parameter logic [PC_W-1:0]      RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_en,
    input  logic            redir_vld,
    input  logic [PC_W-1:0] redir_pc,
    output logic            fi_vld,
    output logic [PC_W-1:0] fi_pc
);

    logic [PC_W-1:0] pc_q;

    // Purpose: the fetched PC is the redirect target when one is raised.
    always_comb begin
        fi_vld = fetch_en;
        fi_pc  = redir_vld ? redir_pc : pc_q;
    end

    // Purpose: step past the fetched PC, or hold the chosen PC when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else if (fetch_en) begin
            pc_q <= fi_pc + PC_W'(1);
        end else begin
            pc_q <= fi_pc;
        end
    end

endmodule

// File: rtl/pfc_penalty.sv
// Module: penalty counter. Adds the number of valid entries discarded by
// the kill mask on each edge. Assumes at most NUM_STG-1 discards a cycle.
module pfc_penalty
    import pfc_pkg::*;
#(
    parameter int unsigned PEN_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_STG-2:0] up_vld,
    input  logic [NUM_STG-2:0] kill_up,
    output logic [PEN_W-1:0]   cnt
);

    localparam int unsigned BUB_W = $clog2(NUM_STG);

    logic [BUB_W-1:0] bubbles;

    // Purpose: count the valid entries that are squashed this cycle.
    always_comb begin
        bubbles = BUB_W'($countones(up_vld & kill_up));
    end

    // Purpose: accumulate bubbles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PEN_W'(bubbles);
        end
    end

endmodule

// File: rtl/pipe_flush_ctl.sv
// Module: top of the six-stage branch flush controller. Tracks valid, PC,
// branch class and target per stage, resolves unconditional branches at
// CO and taken conditional branches at EI, squashes the younger stages
// and counts the bubbles. Assumes one instruction per stage and no stalls.
module pipe_flush_ctl
    import pfc_pkg::*;
#(
    parameter int unsigned     PC_W     = 16,
    parameter int unsigned     PEN_W    = 16,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fetch_en,
    input  logic [1:0]              fetch_kind,
    input  logic [PC_W-1:0]         fetch_target,
    input  logic                    ex_taken,
    output logic [NUM_STG-1:0]      stg_valid,
    output logic [NUM_STG*PC_W-1:0] stg_pc,
    output logic                    redirect_valid,
    output logic [PC_W-1:0]         redirect_pc,
    output logic [PEN_W-1:0]        penalty_cnt
);

    logic [NUM_STG-1:0] vld_q;
    logic [PC_W-1:0]    pc_q   [NUM_STG];
    br_kind_e           kind_q [NUM_STG];
    logic [PC_W-1:0]    tgt_q  [NUM_STG];
    logic [NUM_STG-1:0] kill;
    logic               co_hit;
    logic               ei_hit;
    logic               redir_vld;
    logic [PC_W-1:0]    redir_pc;
    logic               fi_vld;
    logic [PC_W-1:0]    fi_pc;

    pfc_resolve #(.PC_W(PC_W)) u_resolve (
        .co_vld    (vld_q[S_CO]),
        .co_kind   (kind_q[S_CO]),
        .co_tgt    (tgt_q[S_CO]),
        .ei_vld    (vld_q[S_EI]),
        .ei_kind   (kind_q[S_EI]),
        .ei_tgt    (tgt_q[S_EI]),
        .ex_taken  (ex_taken),
        .co_hit    (co_hit),
        .ei_hit    (ei_hit),
        .redir_vld (redir_vld),
        .redir_pc  (redir_pc),
        .kill      (kill)
    );

    pfc_fetch #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_en  (fetch_en),
        .redir_vld (redir_vld),
        .redir_pc  (redir_pc),
        .fi_vld    (fi_vld),
        .fi_pc     (fi_pc)
    );

    // Purpose: chain of stage slots, FI fed by fetch, others by the previous slot.
    for (genvar g = 0; g < NUM_STG; g++) begin : g_stage
        if (g == S_FI) begin : g_head
            pfc_slot #(.PC_W(PC_W)) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_vld  (fi_vld),
                .in_pc   (fi_pc),
                .in_kind (br_kind_e'(fetch_kind)),
                .in_tgt  (fetch_target),
                .kill    (kill[g]),
                .q_vld   (vld_q[g]),
                .q_pc    (pc_q[g]),
                .q_kind  (kind_q[g]),
                .q_tgt   (tgt_q[g])
            );
        end else begin : g_body
            pfc_slot #(.PC_W(PC_W)) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_vld  (vld_q[g-1]),
                .in_pc   (pc_q[g-1]),
                .in_kind (kind_q[g-1]),
                .in_tgt  (tgt_q[g-1]),
                .kill    (kill[g]),
                .q_vld   (vld_q[g]),
                .q_pc    (pc_q[g]),
                .q_kind  (kind_q[g]),
                .q_tgt   (tgt_q[g])
            );
        end
        assign stg_pc[g*PC_W +: PC_W] = pc_q[g];
    end

    pfc_penalty #(.PEN_W(PEN_W)) u_penalty (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_vld  (vld_q[NUM_STG-2:0]),
        .kill_up (kill[NUM_STG-1:1]),
        .cnt     (penalty_cnt)
    );

    assign stg_valid      = vld_q;
    assign redirect_valid = redir_vld;
    assign redirect_pc    = redir_pc;

endmodule

// File: rtl/pfc_chk.sv
// Module: property checker for the flush controller, bound to the top.
// Assumes the stage packing described in the brief.
module pfc_chk
    import pfc_pkg::*;
#(
    parameter int unsigned PC_W  = 16,
    parameter int unsigned PEN_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    fetch_en,
    input logic [NUM_STG-1:0]      stg_valid,
    input logic [NUM_STG*PC_W-1:0] stg_pc,
    input logic                    redirect_valid,
    input logic [PC_W-1:0]         redirect_pc,
    input logic [PEN_W-1:0]        penalty_cnt,
    input logic                    co_hit,
    input logic                    ei_hit
);

    AST_ADVANCE_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_valid |=> stg_valid[NUM_STG-1:1] == $past(stg_valid[NUM_STG-2:0])); // R2

    AST_EI_TO_WO: assert property (@(posedge clk) disable iff (!rst_n)
        stg_valid[S_EI] |=> stg_valid[S_WO] && stg_pc[S_WO*PC_W +: PC_W] == $past(stg_pc[S_EI*PC_W +: PC_W])); // R8

    AST_EARLY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (co_hit && !ei_hit) |=> stg_valid[S_CO:S_DI] == '0); // R3

    AST_LATE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ei_hit |=> stg_valid[S_EI:S_DI] == '0); // R4

    AST_TARGET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && fetch_en) |=> stg_valid[S_FI] && stg_pc[S_FI*PC_W +: PC_W] == $past(redirect_pc)); // R3

    AST_PEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_valid |=> $stable(penalty_cnt)); // R7

    AST_PEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (penalty_cnt - $past(penalty_cnt)) <= PEN_W'(NUM_STG-2)); // R7

endmodule

bind pipe_flush_ctl pfc_chk #(.PC_W(PC_W), .PEN_W(PEN_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_en       (fetch_en),
    .stg_valid      (stg_valid),
    .stg_pc         (stg_pc),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .penalty_cnt    (penalty_cnt),
    .co_hit         (co_hit),
    .ei_hit         (ei_hit)
);

// File: tb/pipe_flush_ctl_tb.sv
module pipe_flush_ctl_tb;

    localparam int unsigned PC_W = 16;
    localparam int unsigned PEN_W = 16;
    localparam int unsigned NSTG = 6;
    localparam int unsigned NVEC = 28;

    typedef struct packed {
        logic        fe;
        logic [1:0]  kind;
        logic [15:0] tgt;
        logic        ext;
        logic        rv;
        logic [15:0] rpc;
        logic [5:0]  vld;
        logic [15:0] pen;
        logic [15:0] fipc;
        logic [15:0] wopc;
        logic [3:0]  req;
    } vec_t;

    // fe kind tgt ext | rv rpc vld pen fipc wopc req
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 6'b000001, 16'd0,  16'h0000, 16'h0000, 4'd2}, // R2
        '{1'b1, 2'd1, 16'h0040, 1'b0, 1'b0, 16'h0000, 6'b000011, 16'd0,  16'h0001, 16'h0000, 4'd2}, // R2
        '{1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 6'b000111, 16'd0,  16'h0002, 16'h0000, 4'd2}, // R2
        '{1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 6'b001111, 16'd0,  16'h0003, 16'h0000, 4'd2}, // R2
        '{1'b1, 2'd0, 16'h0000, 1'b0, 1'b1, 16'h0040, 6'b011001, 16'd2,  16'h0040, 16'h0000, 4'd3}, // R3
        '{1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 6'b110011, 16'd2,  16'h0041, 16'h0000, 4'd3}, // R3
        '{1'b1, 2'd2, 16'h0080, 1'b1, 1'b0, 16'h0000, 6'b100111, 16'd2,  16'h0042, 16'h0001, 4'd9}, // R9
        '{1'b1, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0000, 6'b001111, 16'd2,  16'h0043, 16'h0000, 4'd9}, // R9
        '{1'b1, 2'd3, 16'h00EE, 1'b0, 1'b0, 16'h0000, 6'b011111, 16'd2,  16'h0044, 16'h0000, 4'd8}, // R8
        '{1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 6'b111111, 16'd2,  16'h0045, 16'h0040, 4'd8}, // R8
        '{1'b1, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0000, 6'b111111, 16'd2,  16'h0046, 16'h0041, 4'd5}, // R5
        '{1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 6'b111111, 16'd2,  16'h0047, 16'h0042, 4'd5}, // R5
        '{1'b1, 2'd2, 16'h0090, 1'b0, 1'b0, 16'h0000, 6'b111111, 16'd2,  16'h0048, 16'h0043, 4'd2}, // R2
        '{1'b1, 2'd0, 16'h0000, 1'b1, 1'b0, 16'h0000, 6'b111111, 16'd2,  16'h0049, 16'h0044, 4'd9}, // R9
        '{1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 6'b111111, 16'd2,  16'h004A, 16'h0045, 4'd5}, // R5
        '{1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 6'b111111, 16'd2,  16'h004B, 16'h0046, 4'd5}, // R5
        '{1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 6'b111111, 16'd2,  16'h004C, 16'h0047, 4'd2}, // R2
        '{1'b1, 2'd0, 16'h0000, 1'b1, 1'b1, 16'h0090, 6'b100001, 16'd6,  16'h0090, 16'h0048, 4'd4}, // R4
        '{1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 6'b000010, 16'd6,  16'h0000, 16'h0000, 4'd10}, // R10
        '{1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 6'b000101, 16'd6,  16'h0091, 16'h0000, 4'd10}, // R10
        '{1'b1, 2'd2, 16'h00A0, 1'b0, 1'b0, 16'h0000, 6'b001011, 16'd6,  16'h0092, 16'h0000, 4'd2}, // R2
        '{1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 6'b010111, 16'd6,  16'h0093, 16'h0000, 4'd2}, // R2
        '{1'b1, 2'd1, 16'h00B0, 1'b0, 1'b0, 16'h0000, 6'b101111, 16'd6,  16'h0094, 16'h0090, 4'd8}, // R8
        '{1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 6'b011111, 16'd6,  16'h0095, 16'h0000, 4'd5}, // R5
        '{1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 6'b111111, 16'd6,  16'h0096, 16'h0091, 4'd2}, // R2
        '{1'b1, 2'd0, 16'h0000, 1'b1, 1'b1, 16'h00A0, 6'b100001, 16'd10, 16'h00A0, 16'h0092, 4'd6}, // R6
        '{1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 6'b000011, 16'd10, 16'h00A1, 16'h0000, 4'd6}, // R6
        '{1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 6'b000111, 16'd10, 16'h00A2, 16'h0000, 4'd6}  // R6
    };

    logic                 clk;
    logic                 rst_n;
    logic                 fetch_en;
    logic [1:0]           fetch_kind;
    logic [PC_W-1:0]      fetch_target;
    logic                 ex_taken;
    logic [NSTG-1:0]      stg_valid;
    logic [NSTG*PC_W-1:0] stg_pc;
    logic                 redirect_valid;
    logic [PC_W-1:0]      redirect_pc;
    logic [PEN_W-1:0]     penalty_cnt;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    pipe_flush_ctl #(.PC_W(PC_W), .PEN_W(PEN_W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_en       (fetch_en),
        .fetch_kind     (fetch_kind),
        .fetch_target   (fetch_target),
        .ex_taken       (ex_taken),
        .stg_valid      (stg_valid),
        .stg_pc         (stg_pc),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .penalty_cnt    (penalty_cnt)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic fe, input logic [1:0] k,
                         input logic [15:0] t, input logic x);
        fetch_en     = fe;
        fetch_kind   = k;
        fetch_target = t;
        ex_taken     = x;
    endtask

    initial begin
        drive(1'b0, 2'd0, 16'h0, 1'b0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "valid", 32'(stg_valid), 32'h0);
        check("R1", "penalty", 32'(penalty_cnt), 32'h0);
        check("R1", "redirect", 32'(redirect_valid), 32'h0);
        rst_n = 1'b1;

        // Table walk: drive at negedge, check redirect, check state next negedge
        for (int i = 0; i < int'(NVEC); i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i].req);
            drive(VEC[i].fe, VEC[i].kind, VEC[i].tgt, VEC[i].ext);
            #2;
            check(VEC[i].rv ? tag : "R3", "redirect_valid", 32'(redirect_valid), 32'(VEC[i].rv));
            if (VEC[i].rv)
                check(tag, "redirect_pc", 32'(redirect_pc), 32'(VEC[i].rpc));
            @(negedge clk);
            check(tag, "stg_valid", 32'(stg_valid), 32'(VEC[i].vld));
            check("R7", "penalty_cnt", 32'(penalty_cnt), 32'(VEC[i].pen));
            if (VEC[i].vld[0])
                check(tag, "fi_pc", 32'(stg_pc[0 +: PC_W]), 32'(VEC[i].fipc));
            if (VEC[i].vld[5])
                check("R8", "wo_pc", 32'(stg_pc[5*PC_W +: PC_W]), 32'(VEC[i].wopc));
        end

        // R1: reset in the middle of a run clears everything, fetch restarts at 0
        drive(1'b1, 2'd0, 16'h0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "valid after mid reset", 32'(stg_valid), 32'h0);
        check("R1", "penalty after mid reset", 32'(penalty_cnt), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "fi_pc after reset", 32'(stg_pc[0 +: PC_W]), 32'h0);

        // R7 and R10: unconditional branch with empty FI/DI adds no penalty
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 2'd1, 16'h0020, 1'b0);
        @(negedge clk);
        drive(1'b0, 2'd0, 16'h0, 1'b0);
        @(negedge clk);
        check("R10", "fi idle", 32'(stg_valid), 32'b000010);
        @(negedge clk);
        drive(1'b1, 2'd0, 16'h0, 1'b0);
        #2;
        check("R3", "redirect with gaps", 32'(redirect_valid), 32'h1);
        @(negedge clk);
        check("R7", "no valid squashed", 32'(penalty_cnt), 32'h0);
        check("R3", "valid after gap flush", 32'(stg_valid), 32'b001001);
        check("R3", "fi target", 32'(stg_pc[0 +: PC_W]), 32'h0020);
        @(negedge clk);
        check("R3", "fetch target+1", 32'(stg_pc[0 +: PC_W]), 32'h0021);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule